// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This block keeps the 64-bit control and status word that governs floating-point arithmetic. The word holds a dynamic rounding selection, six sticky exception flags with a summary bit, five trap-disable controls, and the controls that make the datapath flush underflowing results and treat denormal operands as zero. Software reads the whole word and replaces it with a full-word write.

An arithmetic datapath reports each finished operation with a completion strobe, a raw exception vector and four per-instruction qualifiers: dynamic rounding, software completion, inexact reporting and underflow reporting. In the same cycle the block returns the rounding mode the operation must use and whether it must trap, with the causes. On the next clock edge it folds the reported exceptions into the sticky flags. Trapping is the default. A disable bit only takes effect when the instruction asks for software completion, and inexact and underflow are only reported when their qualifier is present.

Top module: `fpcsr_unit`

## Requirements
- R1: After reset the word reads 64'h0800_0000_0000_0000: everything clear except the rounding field at bits 59:58, which holds 2'b10 (to nearest).
- R2: A software write stores bits 62:47 of the write data. Bits 46:0 always read zero. Bit 63 ignores written data and always reads as the OR of the flags at bits 57:52.
- R3: With the dynamic-round qualifier set, the effective rounding output equals bits 59:58 (00 toward zero, 01 toward minus infinity, 10 nearest, 11 toward plus infinity). Without the qualifier it is 2'b10.
- R4: Raw exception bits 0..5 (invalid, divide-by-zero, overflow, underflow, inexact, integer overflow) set flag bits 52..57 in that order on a completing operation. A flag stays set until software writes it to zero.
- R5: Underflow (raw bit 3) is reported, and so can set a flag or trap, only with the underflow qualifier. Inexact (raw bit 4) is reported only with the inexact qualifier.
- R6: A reported overflow, divide-by-zero or invalid raises the trap, with trap-cause bits 2, 1 and 0 respectively. It is suppressed only when software completion is qualified and disable bit 51, 50 or 49 respectively is set. Integer overflow never traps.
- R7: A reported underflow (trap-cause bit 3) or inexact (trap-cause bit 4) traps, unless software completion is qualified and disable bit 61 or 62 respectively is set.
- R8: Raw bit 6 (invalid caused by a denormal operand) acts as an invalid exception. It is dropped, with neither flag nor trap, when bit 47 is set and bit 48 is clear.
- R9: The flush-underflow output follows bit 60 and the denormals-as-zero output follows bit 48 of the stored word.
- R10: When a software write and a completing operation share a cycle, the written value is stored and that operation's reported flags are ORed onto it.
- R11: Without the completion strobe, trap request and trap causes are zero and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_wr_en | input | 1 | Software full-word write strobe |
| sw_wr_data | input | 64 | Software write data |
| csr_rd_data | output | 64 | Current register contents |
| op_done | input | 1 | Operation completion strobe |
| op_exc_raw | input | 7 | Raw exceptions: 0 invalid, 1 div-zero, 2 overflow, 3 underflow, 4 inexact, 5 int overflow, 6 denormal-operand invalid |
| q_dyn_round | input | 1 | Instruction uses dynamic rounding |
| q_sw_complete | input | 1 | Instruction allows software completion |
| q_inexact_en | input | 1 | Instruction reports inexact |
| q_underflow_en | input | 1 | Instruction reports underflow |
| eff_round | output | 2 | Rounding mode for the current operation |
| trap_req | output | 1 | Trap request for the completing operation |
| trap_cause | output | 5 | Trap causes: 0 invalid, 1 div-zero, 2 overflow, 3 underflow, 4 inexact |
| flush_underflow | output | 1 | Flush underflowing results to zero |
| denorm_as_zero | output | 1 | Treat denormal operands as zero |

## Verification
A corrupted stored word is visible on the read port one edge after it occurs. A wrong rounding field or disable bit shows up combinationally in the very next operation's rounding output or trap causes. A flag that fails to stick, or a summary bit out of step with the flags, differs from the bench model on the next read. Random traffic mixes writes, operations and all qualifier combinations, so collisions and gated disables occur often. Directed cycles pin the reset word, reserved bits, the write-and-complete collision and the denormal suppression rule.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

  localparam int CSR_W   = 64;
  localparam int N_FLAG  = 6;
  localparam int N_RAW   = 7;
  localparam int N_TRAP  = 5;
  localparam int RND_W   = 2;

  // Field positions of the architectural word
  localparam int B_SUM     = 63;
  localparam int B_INE_DIS = 62;
  localparam int B_UNF_DIS = 61;
  localparam int B_UFZ     = 60;
  localparam int B_RND_LO  = 58;
  localparam int B_FLAG_LO = 52;
  localparam int B_OVF_DIS = 51;
  localparam int B_DZE_DIS = 50;
  localparam int B_INV_DIS = 49;
  localparam int B_DAZ     = 48;
  localparam int B_DEN_DIS = 47;
  localparam int B_RND_HI  = B_RND_LO + RND_W - 1;
  localparam int B_FLAG_HI = B_FLAG_LO + N_FLAG - 1;

  // Raw exception vector indices
  localparam int E_INV = 0;
  localparam int E_DZE = 1;
  localparam int E_OVF = 2;
  localparam int E_UNF = 3;
  localparam int E_INE = 4;
  localparam int E_IOV = 5;
  localparam int E_DEN = 6;

  typedef enum logic [RND_W-1:0] {
    RM_ZERO = 2'b00,
    RM_NEG  = 2'b01,
    RM_NEAR = 2'b10,
    RM_POS  = 2'b11
  } rmode_e;

  // Writable bits: 62 down to 47
  localparam logic [CSR_W-1:0] WR_MASK   = 64'h7FFF_8000_0000_0000;
  localparam logic [CSR_W-1:0] RESET_VAL = 64'h0800_0000_0000_0000;

  // Disable bit that belongs to each trap cause
  function automatic int dis_pos(input int cause);
    case (cause)
      E_INV:   dis_pos = B_INV_DIS;
      E_DZE:   dis_pos = B_DZE_DIS;
      E_OVF:   dis_pos = B_OVF_DIS;
      E_UNF:   dis_pos = B_UNF_DIS;
      default: dis_pos = B_INE_DIS;
    endcase
  endfunction

endpackage

// File: rtl/fpcsr_round_sel.sv
module fpcsr_round_sel
  import fpcsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_dyn,
  input  logic [RND_W-1:0] rnd_field,
  output logic [RND_W-1:0] eff_round
);

  always_comb begin
    if (q_dyn) eff_round = rnd_field;
    else       eff_round = RM_NEAR;
  end

  AST_STATIC_IS_NEAREST: assert property (@(posedge clk) disable iff (!rst_n)
    !q_dyn |-> (eff_round == 2'b10)); // R3

  AST_DYN_FOLLOWS_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    q_dyn |-> (eff_round == rnd_field)); // R3

endmodule

// File: rtl/fpcsr_exc_qual.sv
module fpcsr_exc_qual
  import fpcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_done,
  input  logic [N_RAW-1:0]  exc_raw,
  input  logic              q_swc,
  input  logic              q_inex,
  input  logic              q_unf,
  input  logic [N_TRAP-1:0] trap_dis,
  input  logic              den_dis,
  input  logic              daz,
  output logic [N_FLAG-1:0] flag_set,
  output logic [N_TRAP-1:0] trap_cause,
  output logic              trap_req
);

  logic              den_inv;
  logic [N_FLAG-1:0] reported;
  logic [N_TRAP-1:0] dis_active;

  // Denormal-operand invalid is dropped only when denormals are not zeroed
  always_comb begin
    den_inv = exc_raw[E_DEN] & ~(den_dis & ~daz);
  end

  always_comb begin
    reported        = '0;
    reported[E_INV] = exc_raw[E_INV] | den_inv;
    reported[E_DZE] = exc_raw[E_DZE];
    reported[E_OVF] = exc_raw[E_OVF];
    reported[E_UNF] = exc_raw[E_UNF] & q_unf;
    reported[E_INE] = exc_raw[E_INE] & q_inex;
    reported[E_IOV] = exc_raw[E_IOV];
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_TRAP; gi++) begin : g_cause
      always_comb begin
        dis_active[gi] = q_swc & trap_dis[gi];
        trap_cause[gi] = op_done & reported[gi] & ~dis_active[gi];
      end
    end
  endgenerate

  always_comb begin
    flag_set = op_done ? reported : '0;
    trap_req = |trap_cause;
  end

  AST_HARD_OVF_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && exc_raw[E_OVF] && !q_swc) |-> (trap_req && trap_cause[E_OVF])); // R6

  AST_DEN_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && exc_raw == 7'b1000000 && den_dis && !daz) |-> (!trap_req && flag_set == '0)); // R8

  AST_QUIET_WITHOUT_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !op_done |-> (!trap_req && flag_set == '0)); // R11

  AST_UNF_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !q_unf |-> !trap_cause[E_UNF]); // R5

endmodule

// File: rtl/fpcsr_reg.sv
module fpcsr_reg
  import fpcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CSR_W-1:0]  wr_data,
  input  logic              op_done,
  input  logic [N_FLAG-1:0] flag_set,
  output logic [CSR_W-1:0]  csr_q
);

  logic [CSR_W-1:0] base;
  logic [CSR_W-1:0] csr_d;
  logic             csr_en;

  // Next-state: write wins, then completing flags are ORed on (R10)
  always_comb begin
    base   = wr_en ? (wr_data & WR_MASK) : csr_q;
    csr_d  = base;
    csr_d[B_FLAG_HI:B_FLAG_LO] = base[B_FLAG_HI:B_FLAG_LO] | flag_set;
    csr_d[B_SUM] = |csr_d[B_FLAG_HI:B_FLAG_LO];
    csr_en = wr_en | op_done;
  end

  // Reset value carries round-to-nearest (R1)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      csr_q <= RESET_VAL;
    else if (csr_en) csr_q <= csr_d;
  end

  AST_SUMMARY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    csr_q[B_SUM] == (|csr_q[B_FLAG_HI:B_FLAG_LO])); // R2

  AST_FLAGS_STICK: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((csr_q[B_FLAG_HI:B_FLAG_LO] & $past(csr_q[B_FLAG_HI:B_FLAG_LO]))
                == $past(csr_q[B_FLAG_HI:B_FLAG_LO]))); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !op_done) |=> $stable(csr_q)); // R11

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (csr_q[B_INE_DIS:B_FLAG_HI+1] == $past(wr_data[B_INE_DIS:B_FLAG_HI+1]))); // R10

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    csr_q[B_DEN_DIS-1:0] == '0); // R2

endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
  import fpcsr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_wr_en,
  input  logic [63:0] sw_wr_data,
  output logic [63:0] csr_rd_data,
  input  logic        op_done,
  input  logic [6:0]  op_exc_raw,
  input  logic        q_dyn_round,
  input  logic        q_sw_complete,
  input  logic        q_inexact_en,
  input  logic        q_underflow_en,
  output logic [1:0]  eff_round,
  output logic        trap_req,
  output logic [4:0]  trap_cause,
  output logic        flush_underflow,
  output logic        denorm_as_zero
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [CSR_W-1:0]  csr_q;
  logic [N_FLAG-1:0] flag_set;
  logic [N_TRAP-1:0] trap_dis;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  always_comb rst_sync_n = rst_pipe[1];

  genvar gi;
  generate
    for (gi = 0; gi < N_TRAP; gi++) begin : g_dis
      always_comb trap_dis[gi] = csr_q[dis_pos(gi)];
    end
  endgenerate

  fpcsr_round_sel u_round (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .q_dyn     (q_dyn_round),
    .rnd_field (csr_q[B_RND_HI:B_RND_LO]),
    .eff_round (eff_round)
  );

  fpcsr_exc_qual u_qual (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .op_done    (op_done),
    .exc_raw    (op_exc_raw),
    .q_swc      (q_sw_complete),
    .q_inex     (q_inexact_en),
    .q_unf      (q_underflow_en),
    .trap_dis   (trap_dis),
    .den_dis    (csr_q[B_DEN_DIS]),
    .daz        (csr_q[B_DAZ]),
    .flag_set   (flag_set),
    .trap_cause (trap_cause),
    .trap_req   (trap_req)
  );

  fpcsr_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (sw_wr_en),
    .wr_data  (sw_wr_data),
    .op_done  (op_done),
    .flag_set (flag_set),
    .csr_q    (csr_q)
  );

  always_comb begin
    csr_rd_data     = csr_q;
    flush_underflow = csr_q[B_UFZ];
    denorm_as_zero  = csr_q[B_DAZ];
  end

  AST_CTRL_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flush_underflow == csr_rd_data[60]) && (denorm_as_zero == csr_rd_data[48])); // R9

endmodule

// File: tb/tb_fpcsr_unit.sv
`timescale 1ns/1ps
module tb_fpcsr_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_wr_en;
  logic [63:0] sw_wr_data;
  logic [63:0] csr_rd_data;
  logic        op_done;
  logic [6:0]  op_exc_raw;
  logic        q_dyn_round, q_sw_complete, q_inexact_en, q_underflow_en;
  logic [1:0]  eff_round;
  logic        trap_req;
  logic [4:0]  trap_cause;
  logic        flush_underflow, denorm_as_zero;

  int total = 0;
  int bad   = 0;
  logic [63:0] exp_csr;
  bit finished = 0;

  always #4 clk = ~clk;

  fpcsr_unit dut (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .csr_rd_data(csr_rd_data), .op_done(op_done), .op_exc_raw(op_exc_raw),
    .q_dyn_round(q_dyn_round), .q_sw_complete(q_sw_complete),
    .q_inexact_en(q_inexact_en), .q_underflow_en(q_underflow_en),
    .eff_round(eff_round), .trap_req(trap_req), .trap_cause(trap_cause),
    .flush_underflow(flush_underflow), .denorm_as_zero(denorm_as_zero)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Reported exceptions per requirement (R4, R5, R8)
  function automatic logic [5:0] f_rep(input logic [63:0] c, input logic [6:0] e,
                                       input logic qi, input logic qu);
    logic den;
    den = e[6] && !(c[47] && !c[48]);
    f_rep = {e[5], e[4] & qi, e[3] & qu, e[2], e[1], e[0] | den};
  endfunction

  // Trap causes (R6, R7, R11)
  function automatic logic [4:0] f_trap(input logic [63:0] c, input logic [6:0] e, input logic op,
                                        input logic qs, input logic qi, input logic qu);
    logic [5:0] r;
    logic [4:0] d;
    r = f_rep(c, e, qi, qu);
    d = {c[62], c[61], c[51], c[50], c[49]};
    f_trap = op ? (r[4:0] & ~(d & {5{qs}})) : 5'b0;
  endfunction

  function automatic logic [63:0] f_next(input logic [63:0] c, input logic wr, input logic [63:0] wd,
                                         input logic op, input logic [5:0] r);
    logic [63:0] n;
    n = wr ? (wd & 64'h7FFF_8000_0000_0000) : c;
    if (op) n[57:52] = n[57:52] | r;
    n[63] = |n[57:52];
    f_next = n;
  endfunction

  task automatic cyc(input logic wr, input logic [63:0] wd, input logic op, input logic [6:0] e,
                     input logic qd, input logic qs, input logic qi, input logic qu);
    logic [63:0] nxt;
    @(negedge clk);
    chk("R4 readback", csr_rd_data, exp_csr);
    chk("R9 flush", {63'b0, flush_underflow}, {63'b0, exp_csr[60]});
    chk("R9 daz", {63'b0, denorm_as_zero}, {63'b0, exp_csr[48]});
    sw_wr_en = wr; sw_wr_data = wd; op_done = op; op_exc_raw = e;
    q_dyn_round = qd; q_sw_complete = qs; q_inexact_en = qi; q_underflow_en = qu;
    #1;
    chk("R3 round", {62'b0, eff_round}, {62'b0, (qd ? exp_csr[59:58] : 2'b10)});
    chk("R6 R7 trap causes", {59'b0, trap_cause}, {59'b0, f_trap(exp_csr, e, op, qs, qi, qu)});
    chk("R6 trap req", {63'b0, trap_req}, {63'b0, |f_trap(exp_csr, e, op, qs, qi, qu)});
    nxt = f_next(exp_csr, wr, wd, op, f_rep(exp_csr, e, qi, qu));
    @(posedge clk);
    exp_csr = nxt;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sw_wr_en = 0; sw_wr_data = '0; op_done = 0; op_exc_raw = '0;
    q_dyn_round = 0; q_sw_complete = 0; q_inexact_en = 0; q_underflow_en = 0;
    exp_csr = 64'h0800_0000_0000_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset word", csr_rd_data, 64'h0800_0000_0000_0000);
    chk("R1 reset trap", {63'b0, trap_req}, 64'd0);

    // R2: full write, reserved and summary handling
    cyc(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R2 write all ones", csr_rd_data, 64'hFFFF_8000_0000_0000);
    cyc(1, 64'h8000_0000_0000_0000, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 summary write ignored", csr_rd_data, 64'h0);

    // R3: each rounding encoding under dynamic qualifier
    for (int m = 0; m < 4; m++) begin
      cyc(1, 64'(m) << 58, 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 1, 0, 0, 0);
    end

    // R5: inexact/underflow without qualifiers leave flags clear
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 7'b0011000, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 unqualified flags", csr_rd_data, 64'h0);

    // R7: underflow disable only with software completion
    cyc(1, 64'h2000_0000_0000_0000, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 7'b0001000, 0, 1, 0, 1);
    chk("R7 underflow disabled", {63'b0, trap_req}, 64'd0);
    cyc(0, 0, 1, 7'b0001000, 0, 0, 0, 1);
    chk("R7 underflow traps", {59'b0, trap_cause}, 64'h8);

    // R8: denormal-operand invalid suppression depends on bit 48
    cyc(1, 64'h0000_8000_0000_0000, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 7'b1000000, 0, 0, 0, 0);
    chk("R8 den suppressed", {63'b0, trap_req}, 64'd0);
    cyc(1, 64'h0001_8000_0000_0000, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 7'b1000000, 0, 0, 0, 0);
    chk("R8 den with daz traps", {59'b0, trap_cause}, 64'h1);

    // R10: write collides with completing operation
    cyc(1, 64'h0000_0000_0000_0000, 1, 7'b0000001, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 collision", csr_rd_data, 64'h8010_0000_0000_0000);

    // R11: no strobe means no trap and no flag change
    cyc(0, 0, 0, 7'b1111111, 0, 0, 1, 1);
    chk("R11 no strobe trap", {63'b0, trap_req}, 64'd0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R11 no strobe flags", csr_rd_data, 64'h8010_0000_0000_0000);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] wd;
      logic [6:0]  e;
      wd = {$urandom(), $urandom()};
      e  = 7'($urandom() & $urandom());
      cyc(($urandom() % 8) == 0, wd, $urandom() % 2, e,
          $urandom() % 2, $urandom() % 2, $urandom() % 2, $urandom() % 2);
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule